// File: doc/BRIEF.md
# Register-Cached Operand Stack

This block is the operand stack of a small stack-machine datapath. The topmost entries sit in a small register window, and older entries move out to a private backing memory with one synchronous read/write port. Commands arrive one per cycle: push a value, pop the top, or apply a two-operand ALU operation (add, subtract, and, or, xor). An ALU operation takes the top two entries as its operands and leaves one result in their place. A short program such as push A, push B, add, pop therefore names no operand addresses at all.

The memory port is used only at the edges of the window. A push that finds every window register occupied first moves the oldest window entry out to memory. A command that leaves fewer than two live window entries, while memory still holds entries, brings one entry back. Each such transfer takes a single cycle, and `busy` is high during that cycle. No command is accepted while `busy` is high.

The top-of-stack and total-depth outputs are valid whenever `busy` is low. Overflow and underflow are reported as one-cycle error pulses, and the command that caused them has no effect.

Top module: `opstack_top`

## Requirements
- R1: Pushes and pops behave last-in first-out. Outside a busy cycle, `tos` shows the newest entry (zero when the stack is empty) and `depth` shows the total number of entries held in the window and in memory. Results appear on the clock edge after the command is accepted.
- R2: `cmd_op` is encoded as 0 nop, 1 push, 2 pop, 3 add, 4 sub, 5 and, 6 or, 7 xor. An ALU command replaces the top two entries with one result, so `depth` drops by one. For sub, the result is the entry below the top minus the top entry.
- R3: A push that finds all REGS window registers occupied, while memory has room, performs exactly one memory write of the oldest window entry. `busy` is high for exactly one cycle, after which `depth` has grown by one and `tos` shows the pushed value.
- R4: A pop or ALU command that leaves fewer than two window entries, while memory holds entries, performs exactly one memory read that restores the most recently spilled entry beneath the window. `busy` is high for exactly one cycle.
- R5: A push into a window with a free register, and a pop or ALU command that leaves at least two window entries, never raise `busy`.
- R6: A push when the stack holds REGS+MEM_DEPTH entries raises `err_overflow` for one cycle, on the edge after acceptance. The push is ignored: `depth` and `tos` stay unchanged.
- R7: A pop on an empty stack, or an ALU command with fewer than two entries in total, raises `err_underflow` for one cycle and leaves `depth` and `tos` unchanged.
- R8: A command presented while `busy` is high is ignored.
- R9: A synchronous active-high reset empties the stack: `depth` is 0, `tos` is 0, and `busy`, `err_overflow` and `err_underflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_data | input | WIDTH | Value for a push |
| busy | output | 1 | Spill or fill cycle in progress; commands refused |
| tos | output | WIDTH | Current top entry, zero when empty |
| depth | output | $clog2(REGS+MEM_DEPTH+1) | Total entries in window and memory |
| err_overflow | output | 1 | One-cycle pulse: push on a full stack |
| err_underflow | output | 1 | One-cycle pulse: pop or ALU command without enough entries |

## Verification
The properties assume that a command is judged only in a cycle where `busy` is low. They also assume that `cmd_op` carries a defined code whenever `cmd_valid` is high.

The directed stimulus never leaves `cmd_valid` high across a spill or fill, except in the one scenario that deliberately offers a command during a busy cycle. Outside that scenario, each command is held for a single cycle and the bench waits for `busy` to fall before sending the next one.

// File: rtl/opstack_pkg.sv
package opstack_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_AND  = 3'd5,
        OP_OR   = 3'd6,
        OP_XOR  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SPILL = 2'd1,
        SEQ_FILL  = 2'd2
    } seq_e;

endpackage

// File: rtl/opstack_alu.sv
module opstack_alu
    import opstack_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] below,
    input  logic [WIDTH-1:0] top,
    output logic [WIDTH-1:0] res
);
    always_comb begin
        case (op)
            OP_ADD:  res = below + top;
            OP_SUB:  res = below - top;
            OP_AND:  res = below & top;
            OP_OR:   res = below | top;
            OP_XOR:  res = below ^ top;
            default: res = top;
        endcase
    end
endmodule

// File: rtl/opstack_spill_ram.sv
module opstack_spill_ram #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/opstack_top.sv
module opstack_top
    import opstack_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter int REGS      = 4,
    parameter int MEM_DEPTH = 16,
    localparam int CAP      = REGS + MEM_DEPTH,
    localparam int DW       = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [WIDTH-1:0] cmd_data,
    output logic             busy,
    output logic [WIDTH-1:0] tos,
    output logic [DW-1:0]    depth,
    output logic             err_overflow,
    output logic             err_underflow
);
    localparam int RCW = $clog2(REGS + 1);
    localparam int MCW = $clog2(MEM_DEPTH + 1);
    localparam int AW  = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;

    typedef struct packed {
        logic [REGS-1:0][WIDTH-1:0] win;
        logic [RCW-1:0]             rcnt;
        logic [MCW-1:0]             mcnt;
        seq_e                       seq;
        logic [WIDTH-1:0]           pend;
        logic                       ovf;
        logic                       udf;
    } state_t;

    state_t s_d, s_q;

    logic [WIDTH-1:0] top_q, below_q, alu_res, ram_rdata;
    logic [DW-1:0]    tot_q;
    logic             ram_we, accept, refill;
    op_e              op;

    assign op     = op_e'(cmd_op);
    assign accept = cmd_valid && (s_q.seq == SEQ_IDLE);
    assign tot_q  = DW'(s_q.rcnt) + DW'(s_q.mcnt);
    assign refill = (s_q.rcnt <= RCW'(2)) && (s_q.mcnt != '0);

    always_comb begin
        top_q   = '0;
        below_q = '0;
        for (int i = 0; i < REGS; i++) begin
            if (i + 1 == int'(s_q.rcnt)) top_q   = s_q.win[i];
            if (i + 2 == int'(s_q.rcnt)) below_q = s_q.win[i];
        end
    end

    opstack_alu #(.WIDTH(WIDTH)) u_alu (
        .op    (op),
        .below (below_q),
        .top   (top_q),
        .res   (alu_res)
    );

    opstack_spill_ram #(.WIDTH(WIDTH), .DEPTH(MEM_DEPTH)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (s_q.mcnt[AW-1:0]),
        .wdata (s_q.win[0]),
        .raddr (AW'(s_q.mcnt - MCW'(1))),
        .rdata (ram_rdata)
    );

    always_comb begin
        s_d     = s_q;
        s_d.ovf = 1'b0;
        s_d.udf = 1'b0;
        ram_we  = 1'b0;
        case (s_q.seq)
            SEQ_IDLE: begin
                if (accept) begin
                    case (op)
                        OP_NOP: ;
                        OP_PUSH: begin
                            if (s_q.rcnt != RCW'(REGS)) begin
                                for (int i = 0; i < REGS; i++) begin
                                    if (i == int'(s_q.rcnt)) s_d.win[i] = cmd_data;
                                end
                                s_d.rcnt = s_q.rcnt + RCW'(1);
                            end else if (s_q.mcnt != MCW'(MEM_DEPTH)) begin
                                s_d.pend = cmd_data;
                                s_d.seq  = SEQ_SPILL;
                            end else begin
                                s_d.ovf = 1'b1;
                            end
                        end
                        OP_POP: begin
                            if (s_q.rcnt == '0) begin
                                s_d.udf = 1'b1;
                            end else begin
                                s_d.rcnt = s_q.rcnt - RCW'(1);
                                if (refill) s_d.seq = SEQ_FILL;
                            end
                        end
                        default: begin
                            if (tot_q < DW'(2)) begin
                                s_d.udf = 1'b1;
                            end else begin
                                for (int i = 0; i < REGS; i++) begin
                                    if (i + 2 == int'(s_q.rcnt)) s_d.win[i] = alu_res;
                                end
                                s_d.rcnt = s_q.rcnt - RCW'(1);
                                if (refill) s_d.seq = SEQ_FILL;
                            end
                        end
                    endcase
                end
            end
            SEQ_SPILL: begin
                ram_we = 1'b1;
                for (int i = 0; i < REGS - 1; i++) begin
                    s_d.win[i] = s_q.win[i+1];
                end
                s_d.win[REGS-1] = s_q.pend;
                s_d.mcnt        = s_q.mcnt + MCW'(1);
                s_d.seq         = SEQ_IDLE;
            end
            SEQ_FILL: begin
                for (int i = 1; i < REGS; i++) begin
                    s_d.win[i] = s_q.win[i-1];
                end
                s_d.win[0] = ram_rdata;
                s_d.rcnt   = s_q.rcnt + RCW'(1);
                s_d.mcnt   = s_q.mcnt - MCW'(1);
                s_d.seq    = SEQ_IDLE;
            end
            default: s_d.seq = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy          = (s_q.seq != SEQ_IDLE);
    assign tos           = top_q;
    assign depth         = tot_q;
    assign err_overflow  = s_q.ovf;
    assign err_underflow = s_q.udf;

endmodule

// File: rtl/opstack_chk.sv
module opstack_chk #(
    parameter int WIDTH     = 32,
    parameter int REGS      = 4,
    parameter int MEM_DEPTH = 16,
    parameter int DW        = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             busy,
    input logic [WIDTH-1:0] tos,
    input logic [DW-1:0]    depth,
    input logic             err_overflow,
    input logic             err_underflow,
    input logic             ram_we
);
    localparam int CAP = REGS + MEM_DEPTH;

    logic take;
    assign take = cmd_valid && !busy;

    // R1
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(depth) <= CAP);

    // R1
    push_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_op == 3'd1 && int'(depth) < CAP) |=> (busy || depth == $past(depth) + DW'(1)));

    // R3
    busy_single_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R3
    spill_deep_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> int'(depth) >= REGS);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_op == 3'd1 && int'(depth) == CAP) |=> (err_overflow && $stable(depth) && $stable(tos)));

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_op == 3'd2 && depth == '0) |=> (err_underflow && depth == '0));

    // R7
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(err_overflow && err_underflow));

endmodule

bind opstack_top opstack_chk #(
    .WIDTH(WIDTH), .REGS(REGS), .MEM_DEPTH(MEM_DEPTH), .DW(DW)
) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .tos(tos), .depth(depth), .err_overflow(err_overflow),
    .err_underflow(err_underflow), .ram_we(ram_we)
);

// File: tb/sim_opstack_top.sv
module sim_opstack_top;
    localparam int W   = 32;
    localparam int N   = 4;
    localparam int MD  = 16;
    localparam int CAP = N + MD;
    localparam int DW  = $clog2(CAP + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [W-1:0]  cmd_data = '0;
    logic          busy, err_overflow, err_underflow;
    logic [W-1:0]  tos;
    logic [DW-1:0] depth;

    opstack_top #(.WIDTH(W), .REGS(N), .MEM_DEPTH(MD)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .busy(busy), .tos(tos), .depth(depth),
        .err_overflow(err_overflow), .err_underflow(err_underflow)
    );

    always #4 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    logic [W-1:0] stk [CAP];
    int msz = 0, rc = 0, mc = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected behaviour from the requirements: returns error and busy expectations.
    task automatic model(input logic [2:0] op, input logic [W-1:0] d,
                         output bit e_ovf, output bit e_udf, output int e_busy);
        logic [W-1:0] a, b, r;
        e_ovf = 0; e_udf = 0; e_busy = 0;
        if (op == 3'd1) begin
            if (msz == CAP) e_ovf = 1;
            else begin
                stk[msz] = d; msz++;
                if (rc < N) rc++;
                else begin mc++; e_busy = 1; end
            end
        end else if (op == 3'd2 || op >= 3'd3) begin
            if ((op == 3'd2 && msz == 0) || (op >= 3'd3 && msz < 2)) e_udf = 1;
            else begin
                if (op >= 3'd3) begin
                    a = stk[msz-2]; b = stk[msz-1];
                    case (op)
                        3'd3: r = a + b;
                        3'd4: r = a - b;
                        3'd5: r = a & b;
                        3'd6: r = a | b;
                        default: r = a ^ b;
                    endcase
                    stk[msz-2] = r;
                end
                msz--; rc--;
                if (rc < 2 && mc > 0) begin rc++; mc--; e_busy = 1; end
            end
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [W-1:0] d,
                         output bit ovf, output bit udf, output int bcyc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        ovf = err_overflow; udf = err_underflow; bcyc = 0;
        while (busy) begin
            bcyc++;
            @(negedge clk);
        end
    endtask

    task automatic check_state(input string req);
        logic [W-1:0] et;
        et = (msz > 0) ? stk[msz-1] : '0;
        chk(int'(depth) == msz, {req, " depth"}, 64'(depth), 64'(msz));
        chk(tos == et, {req, " tos"}, 64'(tos), 64'(et));
    endtask

    task automatic exec(input logic [2:0] op, input logic [W-1:0] d, input string req);
        bit e_ovf, e_udf, ovf, udf;
        int e_busy, bcyc;
        model(op, d, e_ovf, e_udf, e_busy);
        issue(op, d, ovf, udf, bcyc);
        chk(ovf == e_ovf, {req, " err_overflow"}, 64'(ovf), 64'(e_ovf));
        chk(udf == e_udf, {req, " err_underflow"}, 64'(udf), 64'(e_udf));
        chk(bcyc == e_busy, {req, " busy cycles"}, 64'(bcyc), 64'(e_busy));
        check_state(req);
    endtask

    task automatic t_reset();
        chk(depth == '0, "R9 depth", 64'(depth), 0);
        chk(tos == '0, "R9 tos", 64'(tos), 0);
        chk(busy == 1'b0, "R9 busy", 64'(busy), 0);
        chk(!err_overflow && !err_underflow, "R9 errors", 64'({err_overflow, err_underflow}), 0);
    endtask

    task automatic t_lifo();
        exec(3'd1, 32'h11, "R1/R5 push");
        exec(3'd1, 32'h22, "R1/R5 push");
        exec(3'd1, 32'h33, "R1/R5 push");
        exec(3'd0, 32'h99, "R1 nop");
        exec(3'd2, '0, "R1/R5 pop");
        exec(3'd2, '0, "R1 pop");
        exec(3'd2, '0, "R1 pop to empty");
    endtask

    task automatic t_alu();
        exec(3'd1, 32'd10, "R2 push");
        exec(3'd1, 32'd3, "R2 push");
        exec(3'd4, '0, "R2 sub order");
        exec(3'd1, 32'hF0F0_F0F0, "R2 push");
        exec(3'd5, '0, "R2 and");
        exec(3'd1, 32'h0000_0F0F, "R2 push");
        exec(3'd6, '0, "R2 or");
        exec(3'd1, 32'h0000_00FF, "R2 push");
        exec(3'd7, '0, "R2 xor");
        exec(3'd1, 32'hFFFF_FFFF, "R2 push");
        exec(3'd3, '0, "R2 add wrap");
        exec(3'd2, '0, "R2 pop result");
    endtask

    task automatic t_spill_overflow();
        for (int i = 0; i < CAP; i++) exec(3'd1, 32'h100 + 32'(i), "R3 push/spill");
        exec(3'd1, 32'hDEAD, "R6 push on full");
    endtask

    task automatic t_fill_underflow();
        for (int i = 0; i < CAP; i++) exec(3'd2, '0, "R4 pop/fill");
        exec(3'd2, '0, "R7 pop on empty");
        exec(3'd1, 32'h5, "R7 push");
        exec(3'd3, '0, "R7 add with one entry");
        exec(3'd2, '0, "R7 pop");
    endtask

    task automatic t_alu_fill();
        for (int i = 0; i < 8; i++) exec(3'd1, 32'(i + 1), "R4 push");
        for (int i = 0; i < 7; i++) exec(3'd3 + 3'(i % 2), '0, "R4/R2 alu with fill");
        exec(3'd2, '0, "R4 pop last");
    endtask

    task automatic t_busy_ignore();
        bit e_ovf, e_udf;
        int e_busy;
        for (int i = 0; i < N; i++) exec(3'd1, 32'h200 + 32'(i), "R8 fill window");
        model(3'd1, 32'hAAAA, e_ovf, e_udf, e_busy);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_data = 32'hAAAA;
        @(negedge clk);
        chk(busy == 1'b1, "R8 spill busy", 64'(busy), 1);
        cmd_op = 3'd1; cmd_data = 32'hBBBB;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b0, "R8 busy cleared", 64'(busy), 0);
        check_state("R8 command during busy ignored");
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        msz = 0; rc = 0; mc = 0;
        t_reset();
        exec(3'd1, 32'h77, "R9 push after reset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_lifo();
        t_alu();
        t_spill_overflow();
        t_fill_underflow();
        t_alu_fill();
        t_busy_ignore();
        t_mid_reset();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule